// File: doc/BRIEF.md
# Write Leveling Calibration Controller

This block aligns the write strobe with the clock at each memory device on a daisy-chained (fly-by) clock and command bus. It runs once during memory initialization. While it is active it turns on the devices' leveling mode and a special termination setting. It issues single DQS pulses and reads back, on each byte lane's data line, the clock level that the device captured on the pulse's rising edge. The strobe is the sampling edge and the data line carries status, which is the reverse of normal data flow.

All lanes search in parallel, each with its own 6-bit delay tap that starts at 0. Once per pulse, each lane that is still searching moves its tap up by one step. A lane stops when the majority-filtered feedback goes from 0 to 1, and it keeps that tap for later write traffic. A lane that reaches the last tap without such an edge is flagged as failed. When every lane has locked or failed, leveling mode is dropped, then termination is restored, then completion and an overall pass flag are reported. The tap outputs drive the physical delay lines, which sit outside this block.

Top module: `wlev_cal_top`

## Requirements
- R1: After reset, busy, done, pass, lvl_en, odt_lvl and dqs_pulse are 0, every tap is 0 and no lane_err bit is set.
- R2: A start accepted while idle raises lvl_en and odt_lvl in the same cycle and clears done and the taps. The first dqs_pulse comes ENTER_WAIT cycles after that.
- R3: dqs_pulse is a one-cycle pulse that only occurs while lvl_en is high. Successive pulses are settle+5 cycles apart, and a settle value of 0 is treated as 1.
- R4: After each pulse, every lane that is still searching increments its tap by exactly 1 unless that step ends its search.
- R5: A lane locks when its filtered feedback is 1 at a tap and was 0 at an earlier tap of the same run. Its tap then stays at the first tap that gave 1, independently of the other lanes.
- R6: Feedback for a tap is the majority of three successive synchronized samples, so a single-cycle glitch does not change the result.
- R7: Feedback that is already 1 at tap 0 is not a 0-to-1 transition. A lane whose feedback is 1 at every tap fails.
- R8: A lane with no transition by tap 63 sets its lane_err bit and holds tap 63.
- R9: The run has one pulse per step of the slowest lane. lvl_en falls after the last step, and odt_lvl falls one cycle later, together with the rise of done.
- R10: pass is 1 exactly when no lane failed. done, pass, lane_err and the taps hold until the next start. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run (accepted when idle) |
| settle | input | SETTLE_W | Wait cycles between a pulse and sampling (0 acts as 1) |
| lane_fb | input | LANES | Per-lane clock level returned on the data line |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | All lanes locked in the last run |
| lvl_en | output | 1 | Leveling-mode enable toward the devices |
| odt_lvl | output | 1 | Leveling termination setting active |
| dqs_pulse | output | 1 | Single strobe pulse toward the devices |
| taps | output | LANES*TAP_W | Per-lane delay tap, lane i at bits [i*TAP_W +: TAP_W] |
| lane_err | output | LANES | Per-lane failure flag |

## Verification
Let the clock edge that accepts start be edge 1. Then the first pulse is due at edge ENTER_WAIT+1, lvl_en falls at edge ENTER_WAIT+N*(S+5)+1, and done and the fall of odt_lvl come one edge later. Here N is the step count of the slowest lane and S is the effective settle count. The bench computes N and every lane's tap from its own feedback thresholds. It counts edges from the start edge and samples the outputs on the following falling edge, so each event is compared against the exact edge number. Feedback is also driven on falling edges from the tap value, which keeps it stable at every sampling edge.

// File: rtl/wlev_pkg.sv
package wlev_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ENTER, ST_STROBE, ST_WAIT, ST_SAMPLE, ST_STEP, ST_EXIT, ST_DONE
  } wlev_state_t;
endpackage

// File: rtl/wlev_vote.sv
module wlev_vote #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic shift,
  output logic vote
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      win_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (shift) win_q <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
    end
  end

  assign vote = (win_q[0] & win_q[1]) | (win_q[0] & win_q[2]) | (win_q[1] & win_q[2]);
endmodule

// File: rtl/wlev_lane.sv
module wlev_lane #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic             vote,
  output logic [TAP_W-1:0] tap,
  output logic             err,
  output logic             fin_nxt
);
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

  logic seen0_q, locked_q, err_q;
  logic [TAP_W-1:0] tap_q;
  logic fin;

  assign fin     = locked_q | err_q;
  assign fin_nxt = fin | (step & ((vote & seen0_q) | (tap_q == TAP_MAX)));
  assign tap     = tap_q;
  assign err     = err_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tap_q    <= '0;
      seen0_q  <= 1'b0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (step && !fin) begin
      if (vote && seen0_q) begin
        locked_q <= 1'b1;
      end else begin
        if (!vote) seen0_q <= 1'b1;
        if (tap_q == TAP_MAX) err_q <= 1'b1;
        else                  tap_q <= tap_q + 1'b1;
      end
    end
  end

  // R5: a finished lane keeps its tap until cleared
  assert_tap_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (fin && !clr) |=> $stable(tap_q));
  // R4: tap moves by at most one step per cycle outside a clear
  assert_tap_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (tap_q == $past(tap_q) || tap_q == $past(tap_q) + 1'b1));
  // R8: an error flag only sits on the last tap
  assert_err_at_max_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |-> tap_q == TAP_MAX);
endmodule

// File: rtl/wlev_cal_top.sv
module wlev_cal_top
  import wlev_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int TAP_W       = 6,
  parameter int SETTLE_W    = 8,
  parameter int ENTER_WAIT  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [SETTLE_W-1:0]    settle,
  input  logic [LANES-1:0]       lane_fb,
  output logic                   busy,
  output logic                   done,
  output logic                   pass,
  output logic                   lvl_en,
  output logic                   odt_lvl,
  output logic                   dqs_pulse,
  output logic [LANES*TAP_W-1:0] taps,
  output logic [LANES-1:0]       lane_err
);
  localparam int EW_W  = $clog2(ENTER_WAIT + 1);
  localparam int CNT_W = (EW_W > SETTLE_W) ? EW_W : SETTLE_W;
  localparam logic [CNT_W-1:0] ENTER_LIM = CNT_W'(ENTER_WAIT - 1);
  localparam logic [CNT_W-1:0] SAMP_LIM  = CNT_W'(2);

  wlev_state_t st_q, st_nxt;
  logic [CNT_W-1:0] cnt_q, settle_lim;
  logic [LANES-1:0] vote, fin_nxt;
  logic accept, step, shift;

  assign accept     = (st_q == ST_IDLE) && start;
  assign step       = (st_q == ST_STEP);
  assign shift      = (st_q == ST_SAMPLE);
  assign settle_lim = (settle == '0) ? '0 : CNT_W'(settle - 1'b1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wlev_vote #(.SYNC_STAGES(SYNC_STAGES)) u_vote (
      .clk(clk), .rst(rst), .din(lane_fb[g]), .shift(shift), .vote(vote[g])
    );
    wlev_lane #(.TAP_W(TAP_W)) u_lane (
      .clk(clk), .rst(rst), .clr(accept), .step(step), .vote(vote[g]),
      .tap(taps[g*TAP_W +: TAP_W]), .err(lane_err[g]), .fin_nxt(fin_nxt[g])
    );
  end

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_IDLE:   if (start) st_nxt = ST_ENTER;
      ST_ENTER:  if (cnt_q == ENTER_LIM) st_nxt = ST_STROBE;
      ST_STROBE: st_nxt = ST_WAIT;
      ST_WAIT:   if (cnt_q >= settle_lim) st_nxt = ST_SAMPLE;
      ST_SAMPLE: if (cnt_q == SAMP_LIM) st_nxt = ST_STEP;
      ST_STEP:   st_nxt = (&fin_nxt) ? ST_EXIT : ST_STROBE;
      ST_EXIT:   st_nxt = ST_DONE;
      ST_DONE:   st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      lvl_en    <= 1'b0;
      odt_lvl   <= 1'b0;
      dqs_pulse <= 1'b0;
    end else begin
      st_q      <= st_nxt;
      cnt_q     <= (st_nxt != st_q) ? '0 : cnt_q + 1'b1;
      busy      <= (st_nxt != ST_IDLE) && (st_nxt != ST_DONE);
      lvl_en    <= (st_nxt inside {ST_ENTER, ST_STROBE, ST_WAIT, ST_SAMPLE, ST_STEP});
      odt_lvl   <= (st_nxt inside {ST_ENTER, ST_STROBE, ST_WAIT, ST_SAMPLE, ST_STEP, ST_EXIT});
      dqs_pulse <= (st_nxt == ST_STROBE);
      if (accept) begin
        done <= 1'b0;
        pass <= 1'b0;
      end else if (st_nxt == ST_DONE) begin
        done <= 1'b1;
        pass <= ~|lane_err;
      end
    end
  end

  // R3: strobes only go out with leveling mode on
  assert_dqs_in_level_R3: assert property (@(posedge clk) disable iff (rst)
    dqs_pulse |-> (lvl_en && odt_lvl));
  // R3: a strobe is never longer than one cycle
  assert_dqs_single_R3: assert property (@(posedge clk) disable iff (rst)
    dqs_pulse |=> !dqs_pulse);
  // R9: termination stays on whenever leveling mode is on
  assert_odt_covers_R9: assert property (@(posedge clk) disable iff (rst)
    lvl_en |-> odt_lvl);
  // R9: termination drops one cycle after leveling mode
  assert_odt_after_lvl_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(lvl_en) |=> $fell(odt_lvl));
  // R10: completion is never reported while busy
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !lvl_en));
endmodule

// File: tb/tb_wlev_cal_top.sv
module tb_wlev_cal_top;
  localparam int LANES = 4;
  localparam int TAP_W = 6;
  localparam int SW    = 8;
  localparam int EW    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [SW-1:0] settle = '0;
  logic [LANES-1:0] lane_fb = '0;
  logic busy, done, pass, lvl_en, odt_lvl, dqs_pulse;
  logic [LANES*TAP_W-1:0] taps;
  logic [LANES-1:0] lane_err;

  int tests = 0, fails = 0;
  int thr [LANES];
  bit noise_en = 1'b0;
  int ncyc = 0;
  int total_cyc = 0;

  always #2.5 clk = ~clk;

  wlev_cal_top #(.LANES(LANES), .TAP_W(TAP_W), .SETTLE_W(SW), .ENTER_WAIT(EW)) dut (
    .clk(clk), .rst(rst), .start(start), .settle(settle), .lane_fb(lane_fb),
    .busy(busy), .done(done), .pass(pass), .lvl_en(lvl_en), .odt_lvl(odt_lvl),
    .dqs_pulse(dqs_pulse), .taps(taps), .lane_err(lane_err)
  );

  // device model: feedback is 1 once the tap reaches the lane's threshold
  always @(negedge clk) begin
    ncyc <= ncyc + 1;
    for (int i = 0; i < LANES; i++) begin
      lane_fb[i] <= (int'(taps[i*TAP_W +: TAP_W]) >= thr[i]) ^
                    (noise_en && i == 0 && (ncyc % 4 == 0));
    end
  end

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", total_cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int exp_tap(int t);
    return (t >= 1 && t <= 63) ? t : 63;
  endfunction
  function automatic bit exp_err(int t);
    return !(t >= 1 && t <= 63);
  endfunction
  function automatic int exp_steps(int t);
    return (t >= 1 && t <= 63) ? t + 1 : 64;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int s);
    int n = 0, k = 0, strobes = 0, first_k = -1, lvl_fall = -1, odt_fall = -1, done_k = -1;
    int viol = 0, se, prev_lvl = 0, prev_odt = 0;
    bit all_ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (exp_steps(thr[i]) > n) n = exp_steps(thr[i]);
      if (exp_err(thr[i])) all_ok = 1'b0;
    end
    se = (s == 0) ? 1 : s;
    @(negedge clk);
    settle = SW'(s);
    start = 1'b1;
    while (done_k < 0 && k < 20000) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      start = (k == EW + 5);  // R10: start while busy must be ignored
      if (k == 1) check(lvl_en && odt_lvl && busy && !done && taps == '0, "R2 enter", int'(lvl_en), 1);
      if (dqs_pulse) begin
        strobes++;
        if (first_k < 0) first_k = k;
        if (!lvl_en) viol++;
      end
      if (prev_lvl && !lvl_en) lvl_fall = k;
      if (prev_odt && !odt_lvl) odt_fall = k;
      prev_lvl = lvl_en;
      prev_odt = odt_lvl;
      if (done) done_k = k;
    end
    start = 1'b0;
    check(first_k == EW + 1, "R2 first strobe", first_k, EW + 1);
    check(viol == 0, "R3 strobe outside leveling", viol, 0);
    check(strobes == n, "R9 strobe count", strobes, n);
    check(done_k == EW + n * (se + 5) + 2, "R3/R9 done edge", done_k, EW + n * (se + 5) + 2);
    check(lvl_fall == EW + n * (se + 5) + 1, "R9 lvl_en fall", lvl_fall, EW + n * (se + 5) + 1);
    check(odt_fall == lvl_fall + 1, "R9 odt after lvl_en", odt_fall, lvl_fall + 1);
    for (int i = 0; i < LANES; i++) begin
      check(int'(taps[i*TAP_W +: TAP_W]) == exp_tap(thr[i]), "R4/R5/R8 tap",
            int'(taps[i*TAP_W +: TAP_W]), exp_tap(thr[i]));
      check(lane_err[i] == exp_err(thr[i]), "R7/R8 lane_err", int'(lane_err[i]), int'(exp_err(thr[i])));
    end
    check(pass == all_ok, "R10 pass", int'(pass), int'(all_ok));
    repeat (5) @(negedge clk);
    check(done && pass == all_ok && !busy && !lvl_en && !odt_lvl, "R10 hold after done", int'(done), 1);
  endtask

  initial begin
    for (int i = 0; i < LANES; i++) thr[i] = 70;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !pass && !lvl_en && !odt_lvl && !dqs_pulse, "R1 reset outputs", int'(busy), 0);
    check(taps == '0 && lane_err == '0, "R1 reset taps", int'(taps), 0);
    // directed: distinct lanes, each locks independently (R5)
    thr[0] = 5; thr[1] = 17; thr[2] = 1; thr[3] = 40;
    run(2);
    // R7: feedback high at tap 0 never counts as a transition
    thr[0] = 0; thr[1] = 63; thr[2] = 2; thr[3] = 9;
    run(1);
    // R8: no transition at all
    thr[0] = 64; thr[1] = 3; thr[2] = 70; thr[3] = 12;
    run(3);
    // R6: single-cycle glitches on lane 0 are voted out
    noise_en = 1'b1;
    thr[0] = 21; thr[1] = 6; thr[2] = 33; thr[3] = 2;
    run(2);
    noise_en = 1'b0;
    // R3: settle 0 acts as 1
    thr[0] = 4; thr[1] = 7; thr[2] = 10; thr[3] = 3;
    run(0);
    // constrained random
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < LANES; i++) thr[i] = int'($urandom % 70);
      run(int'($urandom % 6));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule